// File: doc/BRIEF.md
# Segment Descriptor Table

This block is the segment lookup stage of a 64-bit address translation unit. It is a small, fully associative table. Each slot holds a tag word and a descriptor word, both 64 bits wide. The segment size is fixed at 256 MB.

A lookup takes an effective address and the current privilege state. It returns the following, all combinationally:
- a hit flag and the matching slot;
- the virtual segment number;
- the twelve attribute bits;
- the page-size selection;
- the protection key;
- the no-execute flag.

Software-style maintenance operations change the table on the next clock edge:
- a write to an indexed slot, with a range check;
- an invalidate that names an address;
- an invalidate that sweeps the whole table.

When a maintenance operation removes a live entry, the block raises a one-cycle flush request for the downstream translation cache.

Top module: `segtab_array`

## Requirements
- R1: A lookup builds a key from the address: bits 63:28 kept, bit 27 set to 1, and bits 26:0 zero. It hits on the lowest-numbered slot whose tag word equals this key in all 64 bits. `lk_slot` gives that slot.
- R2: On a miss, `lk_hit` is 0 and `lk_slot`, `lk_vsid`, `lk_attr`, `lk_page_bits`, `lk_key` and `lk_nx` are all zero.
- R3: On a hit, the outputs come from the hitting slot's descriptor word: `lk_vsid` is bits 61:12, `lk_attr` is bits 11:0, and `lk_nx` is bit 9.
- R4: On a hit, `lk_page_bits` is 24 when descriptor bit 8 is set, and 12 when it is clear.
- R5: On a hit, `lk_key` is descriptor bit 10 when `lk_user` is 1, and descriptor bit 11 when `lk_user` is 0.
- R6: A write uses `wr_opb[11:0]` as the slot. The tag word becomes `wr_opb` with bits 11:0 cleared, so bit 27 of operand B is the valid bit. The descriptor word becomes `wr_opa`. The new contents are visible to lookups after the next clock edge.
- R7: A write whose slot index is NUM_SLOTS or more raises `wr_err` in the same cycle and leaves the table unchanged.
- R8: Invalidate-by-address looks up `inv_ea`. On a hit, it clears bit 27 of the hitting slot's tag and pulses `tlb_flush` for one cycle after the edge. On a miss, it changes nothing and raises no flush.
- R9: Invalidate-all clears bit 27 in slots 1 and up and never touches slot 0. It pulses `tlb_flush` after the edge only if at least one of those slots was valid.
- R10: When operations coincide in one cycle, invalidate-all wins over invalidate-by-address, which wins over a write. The losing operations have no effect.
- R11: A synchronous reset empties the table, so every lookup misses, and holds `tlb_flush` low.
- R12: A slot written with any of operand B bits 26:12 set never hits, even when its segment bits and valid bit match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_ea | input | 64 | Lookup effective address |
| lk_user | input | 1 | 1 = user (problem) state, 0 = supervisor |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | $clog2(NUM_SLOTS) | Hitting slot |
| lk_vsid | output | 50 | Virtual segment number |
| lk_attr | output | 12 | Descriptor attribute bits |
| lk_page_bits | output | 5 | Page offset width, 12 or 24 |
| lk_key | output | 1 | Protection key for the current privilege |
| lk_nx | output | 1 | No-execute |
| wr_en | input | 1 | Write strobe |
| wr_opa | input | 64 | Descriptor word to store |
| wr_opb | input | 64 | Tag word and slot index |
| wr_err | output | 1 | Write slot out of range |
| inv_one_en | input | 1 | Invalidate-by-address strobe |
| inv_ea | input | 64 | Address to invalidate |
| inv_all_en | input | 1 | Invalidate-all strobe |
| tlb_flush | output | 1 | One-cycle flush request |

## Verification
A corrupted tag or descriptor shows up on the lookup outputs in the very cycle the affected segment is presented. A stale valid bit shows up as a hit where the model expects a miss. A wrong clear shows up as a miss, or a hit on a later duplicate slot. The bench therefore probes every pooled segment in both privilege states after each maintenance operation. Flush errors show up one cycle after the operation's edge, and are compared there against the model's count of live entries removed.

// File: rtl/segtab_pkg.sv
package segtab_pkg;
   localparam int WORD_W     = 64;
   localparam int SEG_SHIFT  = 28;
   localparam int VALID_BIT  = 27;
   localparam int IDX_FLD_W  = 12;
   localparam int VSID_LO    = 12;
   localparam int VSID_HI    = 61;
   localparam int VSID_W     = VSID_HI - VSID_LO + 1;
   localparam int ATTR_W     = 12;
   localparam int BIT_KSUP   = 11;
   localparam int BIT_KUSER  = 10;
   localparam int BIT_NX     = 9;
   localparam int BIT_LARGE  = 8;
   localparam int PB_W       = 5;
   localparam logic [PB_W-1:0] PB_BASE  = PB_W'(12);
   localparam logic [PB_W-1:0] PB_LARGE = PB_W'(24);

   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t seg_key(input word_t ea);
      word_t k;
      k = ea & ~((word_t'(1) << SEG_SHIFT) - word_t'(1));
      k[VALID_BIT] = 1'b1;
      return k;
   endfunction
endpackage

// File: rtl/segtab_match.sv
module segtab_match
   import segtab_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
)(
   input  word_t             tags [NUM_SLOTS],
   input  word_t             ea,
   output logic              hit,
   output logic [SLOT_W-1:0] slot
);
   word_t key;
   logic [NUM_SLOTS-1:0] eq;

   assign key = seg_key(ea);

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      assign eq[g] = (tags[g] == key);
   end

   always_comb begin
      hit  = 1'b0;
      slot = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (eq[i]) begin
            hit  = 1'b1;
            slot = SLOT_W'(i);
         end
      end
   end
endmodule

// File: rtl/segtab_decode.sv
module segtab_decode
   import segtab_pkg::*;
(
   input  logic              hit,
   input  word_t             desc,
   input  logic              user,
   output logic [VSID_W-1:0] vsid,
   output logic [ATTR_W-1:0] attr,
   output logic [PB_W-1:0]   page_bits,
   output logic              key,
   output logic              nx
);
   always_comb begin
      vsid      = '0;
      attr      = '0;
      page_bits = '0;
      key       = 1'b0;
      nx        = 1'b0;
      if (hit) begin
         vsid      = desc[VSID_HI:VSID_LO];
         attr      = desc[ATTR_W-1:0];
         page_bits = desc[BIT_LARGE] ? PB_LARGE : PB_BASE;
         key       = user ? desc[BIT_KUSER] : desc[BIT_KSUP];
         nx        = desc[BIT_NX];
      end
   end
endmodule

// File: rtl/segtab_array.sv
module segtab_array
   import segtab_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [63:0]       lk_ea,
   input  logic              lk_user,
   output logic              lk_hit,
   output logic [SLOT_W-1:0] lk_slot,
   output logic [49:0]       lk_vsid,
   output logic [11:0]       lk_attr,
   output logic [4:0]        lk_page_bits,
   output logic              lk_key,
   output logic              lk_nx,
   input  logic              wr_en,
   input  logic [63:0]       wr_opa,
   input  logic [63:0]       wr_opb,
   output logic              wr_err,
   input  logic              inv_one_en,
   input  logic [63:0]       inv_ea,
   input  logic              inv_all_en,
   output logic              tlb_flush
);
   initial begin : g_param_check
      p_slots_range: assert (NUM_SLOTS >= 2 && NUM_SLOTS <= (1 << IDX_FLD_W))
         else $fatal(1, "NUM_SLOTS out of range");
   end

   word_t tag_q  [NUM_SLOTS];
   word_t desc_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] valid_v;
   logic [IDX_FLD_W-1:0] wr_idx;
   logic [SLOT_W-1:0]    wr_slot;
   logic                 i_hit;
   logic [SLOT_W-1:0]    i_slot;
   logic                 flush_q;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_valid
      assign valid_v[g] = tag_q[g][VALID_BIT];
   end

   assign wr_idx  = wr_opb[IDX_FLD_W-1:0];
   assign wr_slot = wr_idx[SLOT_W-1:0];
   assign wr_err  = wr_en && (32'(wr_idx) >= NUM_SLOTS);

   segtab_match #(.NUM_SLOTS(NUM_SLOTS)) i_lk_match (
      .tags(tag_q), .ea(lk_ea), .hit(lk_hit), .slot(lk_slot)
   );

   segtab_match #(.NUM_SLOTS(NUM_SLOTS)) i_inv_match (
      .tags(tag_q), .ea(inv_ea), .hit(i_hit), .slot(i_slot)
   );

   segtab_decode i_decode (
      .hit(lk_hit), .desc(desc_q[lk_slot]), .user(lk_user),
      .vsid(lk_vsid), .attr(lk_attr), .page_bits(lk_page_bits),
      .key(lk_key), .nx(lk_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            tag_q[i]  <= '0;
            desc_q[i] <= '0;
         end
         flush_q <= 1'b0;
      end else if (inv_all_en) begin
         for (int i = 1; i < NUM_SLOTS; i++) tag_q[i][VALID_BIT] <= 1'b0;
         flush_q <= |valid_v[NUM_SLOTS-1:1];
      end else if (inv_one_en) begin
         if (i_hit) tag_q[i_slot][VALID_BIT] <= 1'b0;
         flush_q <= i_hit;
      end else begin
         flush_q <= 1'b0;
         if (wr_en && !wr_err) begin
            tag_q[wr_slot]  <= {wr_opb[63:IDX_FLD_W], {IDX_FLD_W{1'b0}}};
            desc_q[wr_slot] <= wr_opa;
         end
      end
   end

   assign tlb_flush = flush_q;

   p_flush_cause_r8: assert property (@(posedge clk) disable iff (rst)
      tlb_flush |-> $past(inv_one_en || inv_all_en));

   p_inv_one_clears_r8: assert property (@(posedge clk) disable iff (rst)
      (inv_one_en && !inv_all_en && i_hit) |=> !valid_v[$past(i_slot)]);

   p_slot0_kept_r9: assert property (@(posedge clk) disable iff (rst)
      inv_all_en |=> valid_v[0] == $past(valid_v[0]));

   p_sweep_empties_r9: assert property (@(posedge clk) disable iff (rst)
      inv_all_en |=> (valid_v[NUM_SLOTS-1:1] == '0));

   p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_err && !inv_one_en && !inv_all_en)
      |=> tag_q[$past(wr_slot)] == {$past(wr_opb[63:IDX_FLD_W]), {IDX_FLD_W{1'b0}}});
endmodule

// File: tb/test_segtab_array.sv
`timescale 1ns/1ps
module test_segtab_array;
   localparam int N = 32;
   localparam int SW = $clog2(N);

   logic clk = 1'b0;
   logic rst;
   logic [63:0] lk_ea, wr_opa, wr_opb, inv_ea;
   logic lk_user, wr_en, inv_one_en, inv_all_en;
   logic lk_hit, lk_key, lk_nx, wr_err, tlb_flush;
   logic [SW-1:0] lk_slot;
   logic [49:0] lk_vsid;
   logic [11:0] lk_attr;
   logic [4:0]  lk_page_bits;

   always #2 clk = ~clk;

   segtab_array #(.NUM_SLOTS(N)) i_segtab_array (
      .clk, .rst, .lk_ea, .lk_user, .lk_hit, .lk_slot, .lk_vsid, .lk_attr,
      .lk_page_bits, .lk_key, .lk_nx, .wr_en, .wr_opa, .wr_opb, .wr_err,
      .inv_one_en, .inv_ea, .inv_all_en, .tlb_flush
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [63:0] m_tag [N];
   logic [63:0] m_desc [N];

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mkey(logic [63:0] ea);
      return {ea[63:28], 1'b1, 27'b0};
   endfunction

   function automatic int m_find(logic [63:0] ea);
      for (int i = 0; i < N; i++) if (m_tag[i] == mkey(ea)) return i;
      return -1;
   endfunction

   function automatic logic [63:0] seg_ea(int k);
      return {28'h0, 8'(k), 28'($urandom)};
   endfunction

   task automatic probe(logic [63:0] ea, logic user);
      int s;
      logic [63:0] d;
      lk_ea = ea; lk_user = user;
      #1;
      s = m_find(ea);
      if (s < 0) begin
         check("R2 hit", 64'(lk_hit), 0);
         check("R2 slot", 64'(lk_slot), 0);
         check("R2 vsid", 64'(lk_vsid), 0);
         check("R2 attr", 64'(lk_attr), 0);
         check("R2 pbits", 64'(lk_page_bits), 0);
         check("R2 key", 64'(lk_key), 0);
         check("R2 nx", 64'(lk_nx), 0);
      end else begin
         d = m_desc[s];
         check("R1 hit", 64'(lk_hit), 1);
         check("R1 slot", 64'(lk_slot), 64'(s));
         check("R3 vsid", 64'(lk_vsid), 64'(d[61:12]));
         check("R3 attr", 64'(lk_attr), 64'(d[11:0]));
         check("R3 nx", 64'(lk_nx), 64'(d[9]));
         check("R4 pbits", 64'(lk_page_bits), d[8] ? 64'd24 : 64'd12);
         check("R5 key", 64'(lk_key), 64'(user ? d[10] : d[11]));
      end
   endtask

   task automatic probe_pool();
      for (int k = 0; k < 8; k++) probe(seg_ea(k), 1'($urandom));
   endtask

   // Apply one cycle of operations; model mirrors requirements R6-R10.
   task automatic cycle_op(logic we, logic [63:0] a, logic [63:0] b,
                           logic io, logic [63:0] iea, logic ia);
      logic exp_err, exp_flush;
      int s;
      @(negedge clk);
      wr_en = we; wr_opa = a; wr_opb = b;
      inv_one_en = io; inv_ea = iea; inv_all_en = ia;
      #1;
      exp_err = we && (b[11:0] >= 12'(N));
      check("R7 wr_err", 64'(wr_err), 64'(exp_err));
      exp_flush = 1'b0;
      if (ia) begin
         for (int i = 1; i < N; i++) begin
            if (m_tag[i][27]) exp_flush = 1'b1;
            m_tag[i][27] = 1'b0;
         end
      end else if (io) begin
         s = m_find(iea);
         if (s >= 0) begin m_tag[s][27] = 1'b0; exp_flush = 1'b1; end
      end else if (we && !exp_err) begin
         m_tag[b[11:0]]  = {b[63:12], 12'h0};
         m_desc[b[11:0]] = a;
      end
      @(negedge clk);
      wr_en = 0; inv_one_en = 0; inv_all_en = 0;
      check(ia ? "R9 flush" : "R8 flush", 64'(tlb_flush), 64'(exp_flush));
   endtask

   function automatic logic [63:0] wb(int k, logic v, int slot);
      return {28'h0, 8'(k), v, 15'h0, 12'(slot)};
   endfunction

   task automatic do_write(int k, logic v, int slot, logic [63:0] a);
      cycle_op(1, a, wb(k, v, slot), 0, 0, 0);
   endtask

   initial begin
      #(4ns * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5e6a11));
      for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_desc[i] = '0; end
      rst = 1; wr_en = 0; inv_one_en = 0; inv_all_en = 0;
      wr_opa = 0; wr_opb = 0; inv_ea = 0; lk_ea = 0; lk_user = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      // R11: empty after reset
      check("R11 flush", 64'(tlb_flush), 0);
      probe_pool();

      // R6/R3/R4/R5: directed descriptor bits, both privileges
      do_write(3, 1, 5, 64'h3ABC_DEF0_1234_5D00);
      probe(seg_ea(3), 0);
      probe(seg_ea(3), 1);
      do_write(4, 1, 6, 64'h0000_1111_2222_3000);
      probe(seg_ea(4), 0);
      probe(seg_ea(4), 1);
      // R1: duplicate tag, lowest slot wins
      do_write(3, 1, 2, 64'h0000_0000_0000_0800);
      probe(seg_ea(3), 0);
      // R12: stray bits 26:12 prevent a hit
      cycle_op(1, 64'hFFF, {28'h0, 8'd7, 1'b1, 15'h0040, 12'd9}, 0, 0, 0);
      probe(seg_ea(7), 0);
      // R6: write with valid bit clear
      do_write(6, 0, 10, 64'h123);
      probe(seg_ea(6), 0);
      // R7: out-of-range writes leave table unchanged
      cycle_op(1, 64'hDEAD, wb(3, 1, N), 0, 0, 0);
      cycle_op(1, 64'hDEAD, wb(3, 1, 4095), 0, 0, 0);
      probe(seg_ea(3), 1);
      // R8: miss invalidation, then hit invalidation
      cycle_op(0, 0, 0, 1, seg_ea(5), 0);
      cycle_op(0, 0, 0, 1, seg_ea(3), 0);
      probe(seg_ea(3), 0);
      // R10: invalidate-all beats invalidate-one and write
      do_write(1, 1, 0, 64'h0F00);
      cycle_op(1, 64'h55, wb(2, 1, 12), 1, seg_ea(1), 1);
      probe_pool();
      // R9: slot 0 survives, second sweep raises no flush
      cycle_op(0, 0, 0, 0, 0, 1);
      probe(seg_ea(1), 1);
      // R10: invalidate-one beats write
      do_write(2, 1, 4, 64'h0C00);
      cycle_op(1, 64'h77, wb(5, 1, 8), 1, seg_ea(2), 0);
      probe_pool();

      for (int it = 0; it < 600; it++) begin
         int op;
         int k;
         op = int'($urandom % 10);
         k  = int'($urandom % 8);
         if (op < 6) begin
            logic [63:0] b;
            b = wb(k, ($urandom % 8) != 0, int'($urandom % (N + 4)));
            if ($urandom % 10 == 0) b[26:12] = 15'($urandom) | 15'h1;
            cycle_op(1, {$urandom, $urandom}, b, 0, 0, 0);
         end else if (op < 9) begin
            cycle_op(0, 0, 0, 1, seg_ea(k), 0);
         end else begin
            cycle_op(($urandom % 2) == 1, {$urandom, $urandom},
                     wb(k, 1, int'($urandom % N)), ($urandom % 2) == 1,
                     seg_ea(k), ($urandom % 4) == 0);
         end
         probe_pool();
      end

      // R11: reset mid-run empties table
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      for (int i = 0; i < N; i++) m_tag[i] = '0;
      check("R11 flush", 64'(tlb_flush), 0);
      probe_pool();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule